// File: doc/BRIEF.md
# PWM Configuration Register Bank

This block is the configuration store behind a multi-channel PWM generator. A bus front end, for example a serial-bus target that has already decoded a transaction, presents an 8-bit address and 8-bit data with a write strobe or a read strobe. The bank keeps two mode bytes, a prescale byte and four timing bytes for each channel. It drives the decoded fields straight to the PWM generator. Each channel has a 12-bit turn-on count, a 12-bit turn-off count and two force flags. The bank also drives the sleep, invert and drive-style controls and the prescale value.

A group of broadcast addresses near the top of the map writes one byte into the matching slot of every channel in the same cycle. This lets software set all channels with a single access. Broadcast addresses are write-only and read as zero.

The prescale byte is protected. A write to it is accepted only while the sleep flag is set, and at any other time it is dropped without effect. The bank comes out of reset asleep, so software can set the prescale before it starts the outputs.

Top module: `pwm_cfg_regbank`

## Requirements
- R1: After reset, mode byte 1 is 0x10 (sleep set), mode byte 2 is 0x04, prescale is 0x1E, every channel has ON count 0 with no force-on flag and OFF count 0 with the force-off flag set, and `rd_data` is 0x00.
- R2: Mode byte 1 is at 0x00 and mode byte 2 is at 0x01, and each holds all 8 bits written to it. `sleep_o` is mode-1 bit 4, `invert_o` is mode-2 bit 4 and `totem_o` is mode-2 bit 2.
- R3: Channel n (0..NUM_CH-1) keeps ON low, ON high, OFF low and OFF high at 0x06+4n, 0x07+4n, 0x08+4n and 0x09+4n. Its 12-bit counts on `ch_on_o`/`ch_off_o` (bits 12n+11:12n) are {high[3:0], low}, and `full_on_o[n]`/`full_off_o[n]` are bit 4 of the ON and OFF high bytes.
- R4: The ON and OFF high bytes store only bits 4:0, and bits 7:5 read back as 0.
- R5: A write to 0xFA, 0xFB, 0xFC or 0xFD (ON low, ON high, OFF low, OFF high) updates that byte in every channel at the same clock edge.
- R6: Reads of 0xFA..0xFD return 0x00.
- R7: A write to prescale (0xFE) takes effect only when the stored sleep flag is 1 at that edge. Otherwise the write is dropped.
- R8: Addresses 0x02..0x05, the addresses from the end of the channel array up to 0xF9, and 0xFF read as 0x00, and writes to them change no register.
- R9: A read strobe loads `rd_data` at the next clock edge and `rd_data` holds its value while there is no strobe. A read and a write to the same address in one cycle return the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| sleep_o | output | 1 | Sleep flag |
| invert_o | output | 1 | Output invert select |
| totem_o | output | 1 | Totem-pole (1) or open-drain (0) drive |
| prescale_o | output | 8 | Prescale value |
| ch_on_o | output | 12*NUM_CH | Per-channel 12-bit ON counts |
| ch_off_o | output | 12*NUM_CH | Per-channel 12-bit OFF counts |
| full_on_o | output | NUM_CH | Per-channel force-on flags |
| full_off_o | output | NUM_CH | Per-channel force-off flags |

## Verification
The bench builds the bank with its default of 16 channels. This makes the full address map reachable: the first channel, the last channel at 0x42..0x45, and the first unimplemented address after the array at 0x46. It also lets a single broadcast write be checked on channels at both ends and in the middle. The default prescale reset value of 0x1E lets the bench tell a dropped prescale write apart from a reset.

// File: rtl/pwm_cfg_regbank.sv
module pwm_cfg_regbank #(
  parameter int NUM_CH = 16,
  parameter logic [7:0] PRESCALE_RST = 8'h1E
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [7:0]            addr,
  input  logic [7:0]            wr_data,
  output logic [7:0]            rd_data,
  output logic                  sleep_o,
  output logic                  invert_o,
  output logic                  totem_o,
  output logic [7:0]            prescale_o,
  output logic [12*NUM_CH-1:0]  ch_on_o,
  output logic [12*NUM_CH-1:0]  ch_off_o,
  output logic [NUM_CH-1:0]     full_on_o,
  output logic [NUM_CH-1:0]     full_off_o
);
  localparam logic [7:0] A_MODE1 = 8'h00;
  localparam logic [7:0] A_MODE2 = 8'h01;
  localparam logic [7:0] A_CH0   = 8'h06;
  localparam int         CH_END  = 6 + 4 * NUM_CH;
  localparam logic [7:0] A_BC_LO = 8'hFA;
  localparam logic [7:0] A_BC_HI = 8'hFD;
  localparam logic [7:0] A_PRE   = 8'hFE;

  logic [7:0] mode1, mode2, prescale;
  logic [7:0] on_lo  [NUM_CH];
  logic [4:0] on_hi  [NUM_CH];
  logic [7:0] off_lo [NUM_CH];
  logic [4:0] off_hi [NUM_CH];

  logic       in_ch, bcast;
  logic [7:0] ch_idx;
  logic [1:0] byte_sel;
  logic [7:0] rd_mux;

  assign in_ch    = (addr >= A_CH0) && (int'(addr) < CH_END);
  assign bcast    = (addr >= A_BC_LO) && (addr <= A_BC_HI);
  assign ch_idx   = (addr - A_CH0) >> 2;
  assign byte_sel = addr[1:0] + 2'd2;

  assign sleep_o    = mode1[4];
  assign invert_o   = mode2[4];
  assign totem_o    = mode2[2];
  assign prescale_o = prescale;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode1    <= 8'h10;
      mode2    <= 8'h04;
      prescale <= PRESCALE_RST;
    end else if (wr_en) begin
      if (addr == A_MODE1) mode1 <= wr_data;
      if (addr == A_MODE2) mode2 <= wr_data;
      if (addr == A_PRE && mode1[4]) prescale <= wr_data;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    assign hit = wr_en && (bcast || (in_ch && ch_idx == 8'(i)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        on_lo[i]  <= 8'h00;
        on_hi[i]  <= 5'h00;
        off_lo[i] <= 8'h00;
        off_hi[i] <= 5'h10;
      end else if (hit) begin
        case (byte_sel)
          2'd0: on_lo[i]  <= wr_data;
          2'd1: on_hi[i]  <= wr_data[4:0];
          2'd2: off_lo[i] <= wr_data;
          default: off_hi[i] <= wr_data[4:0];
        endcase
      end
    end

    assign ch_on_o[12*i +: 12]  = {on_hi[i][3:0], on_lo[i]};
    assign ch_off_o[12*i +: 12] = {off_hi[i][3:0], off_lo[i]};
    assign full_on_o[i]  = on_hi[i][4];
    assign full_off_o[i] = off_hi[i][4];

    // R5
    bcast_fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_BC_LO) |=> (ch_on_o[12*i +: 8] == $past(wr_data)));
  end

  always_comb begin
    rd_mux = 8'h00;
    if (addr == A_MODE1) rd_mux = mode1;
    else if (addr == A_MODE2) rd_mux = mode2;
    else if (addr == A_PRE) rd_mux = prescale;
    else if (in_ch) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_idx == 8'(i)) begin
          case (byte_sel)
            2'd0: rd_mux = on_lo[i];
            2'd1: rd_mux = {3'b000, on_hi[i]};
            2'd2: rd_mux = off_lo[i];
            default: rd_mux = {3'b000, off_hi[i]};
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= 8'h00;
    else if (rd_en) rd_data <= rd_mux;
  end

  // R7
  prescale_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PRE && !sleep_o) |=> $stable(prescale_o));

  // R6
  bcast_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bcast) |=> (rd_data == 8'h00));

  // R4
  high_byte_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && in_ch && addr[0]) |=> (rd_data[7:5] == 3'b000));

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr >= 8'h02) && (addr <= 8'h05)) |=> (rd_data == 8'h00));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R2
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MODE1) |=> (sleep_o == $past(wr_data[4])));
endmodule

// File: tb/pwm_cfg_regbank_tb_top.sv
`timescale 1ns/1ps
module pwm_cfg_regbank_tb_top;
  localparam int NUM_CH = 16;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = 8'h00, wr_data = 8'h00, rd_data, prescale_o;
  logic sleep_o, invert_o, totem_o;
  logic [12*NUM_CH-1:0] ch_on_o, ch_off_o;
  logic [NUM_CH-1:0] full_on_o, full_off_o;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pwm_cfg_regbank #(.NUM_CH(NUM_CH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .sleep_o(sleep_o), .invert_o(invert_o),
    .totem_o(totem_o), .prescale_o(prescale_o), .ch_on_o(ch_on_o),
    .ch_off_o(ch_off_o), .full_on_o(full_on_o), .full_off_o(full_off_o));

  // {req[3:0], is_write, addr[7:0], data_or_expected[7:0]}
  localparam int NV = 32;
  localparam logic [20:0] VEC [NV] = '{
    {4'd1, 1'b0, 8'hFE, 8'h1E},  // R1 prescale reset
    {4'd1, 1'b0, 8'h00, 8'h10},  // R1 mode1 reset
    {4'd1, 1'b0, 8'h01, 8'h04},  // R1 mode2 reset
    {4'd1, 1'b0, 8'h09, 8'h10},  // R1 ch0 OFF high reset
    {4'd7, 1'b1, 8'hFE, 8'h79},  // R7 write while asleep
    {4'd7, 1'b0, 8'hFE, 8'h79},
    {4'd2, 1'b1, 8'h00, 8'h00},  // R2 wake
    {4'd2, 1'b0, 8'h00, 8'h00},
    {4'd7, 1'b1, 8'hFE, 8'h05},  // R7 write while awake dropped
    {4'd7, 1'b0, 8'hFE, 8'h79},
    {4'd2, 1'b1, 8'h01, 8'h14},  // R2 mode2
    {4'd2, 1'b0, 8'h01, 8'h14},
    {4'd4, 1'b1, 8'h07, 8'hFF},  // R4 ch0 ON high
    {4'd4, 1'b0, 8'h07, 8'h1F},
    {4'd4, 1'b1, 8'h45, 8'h3C},  // R4 ch15 OFF high
    {4'd4, 1'b0, 8'h45, 8'h1C},
    {4'd3, 1'b1, 8'h42, 8'hAB},  // R3 ch15 ON low
    {4'd3, 1'b0, 8'h42, 8'hAB},
    {4'd5, 1'b1, 8'hFC, 8'h5A},  // R5 broadcast OFF low
    {4'd5, 1'b0, 8'h08, 8'h5A},
    {4'd5, 1'b0, 8'h44, 8'h5A},
    {4'd5, 1'b0, 8'h20, 8'h5A},
    {4'd6, 1'b0, 8'hFC, 8'h00},  // R6
    {4'd6, 1'b0, 8'hFB, 8'h00},
    {4'd8, 1'b1, 8'h03, 8'hFF},  // R8
    {4'd8, 1'b0, 8'h03, 8'h00},
    {4'd8, 1'b1, 8'hFF, 8'h12},
    {4'd8, 1'b0, 8'hFF, 8'h00},
    {4'd8, 1'b1, 8'h46, 8'h77},
    {4'd8, 1'b0, 8'h46, 8'h00},
    {4'd8, 1'b0, 8'h42, 8'hAB},
    {4'd8, 1'b0, 8'h01, 8'h14}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] q);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; q = rd_data;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    check("R1 full_off_o", 32'(full_off_o), 32'hFFFF);
    check("R1 full_on_o", 32'(full_on_o), 32'h0);
    check("R1 prescale_o", 32'(prescale_o), 32'h1E);
    check("R1 rd_data", 32'(rd_data), 32'h0);
    check("R1 sleep_o", 32'(sleep_o), 32'h1);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][16]) do_write(VEC[v][15:8], VEC[v][7:0]);
      else begin
        do_read(VEC[v][15:8], q);
        check($sformatf("R%0d vector %0d addr %h", VEC[v][20:17], v, VEC[v][15:8]),
              32'(q), 32'(VEC[v][7:0]));
      end
    end

    check("R2 invert_o", 32'(invert_o), 32'h1);
    check("R2 totem_o", 32'(totem_o), 32'h1);
    check("R2 sleep_o", 32'(sleep_o), 32'h0);
    check("R3 ch15 off count", 32'(ch_off_o[12*15 +: 12]), 32'hC5A);
    check("R3 ch15 full_off", 32'(full_off_o[15]), 32'h1);
    check("R3 ch0 on count", 32'(ch_on_o[11:0]), 32'hF00);
    check("R3 ch0 full_on", 32'(full_on_o[0]), 32'h1);

    do_write(8'hFD, 8'h00);  // R5 broadcast clears force-off everywhere
    check("R5 full_off_o", 32'(full_off_o), 32'h0);
    check("R5 ch7 off count", 32'(ch_off_o[12*7 +: 12]), 32'h05A);

    @(negedge clk);  // R9 same-cycle read and write returns old value
    wr_en = 1'b1; rd_en = 1'b1; addr = 8'h06; wr_data = 8'h33;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    check("R9 read during write", 32'(rd_data), 32'h00);
    repeat (3) @(negedge clk);
    check("R9 rd_data hold", 32'(rd_data), 32'h00);
    do_read(8'h06, q);
    check("R9 read after write", 32'(q), 32'h33);

    do_write(8'h00, 8'h10);  // R7 sleep again, prescale accepted
    do_write(8'hFE, 8'h03);
    check("R7 prescale_o", 32'(prescale_o), 32'h03);

    @(negedge clk); rst_n = 1'b0;  // R1 reset mid-run
    @(negedge clk);
    check("R1 prescale after reset", 32'(prescale_o), 32'h1E);
    check("R1 full_off after reset", 32'(full_off_o), 32'hFFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule